// File: doc/BRIEF.md
# Shift Unit with Carry and Extend Flags

This block shifts a 32-bit operand left logically, right logically or right arithmetically by an unsigned count of up to 63 positions, and reports the carry (the last bit moved out of the operand) and an extend flag alongside the result. It is meant for the integer datapath of a processor core. The flag logic that later turns the carry into condition codes sits downstream of it.

Counts of zero, 1 to 31, exactly 32 and 33 to 63 each follow their own rule. A zero count leaves the operand unchanged and passes the incoming carry flag through. The extend flag only changes when a real shift happens. All outputs are registered and appear one clock after the inputs are sampled.

Top module: `shf_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_o`, `cout_o` and `xout_o` become 0.
- R2: The full 6-bit count field is meaningful, so counts 33 to 63 are valid inputs and follow the rules below, with no wrap to smaller counts.
- R3: With a count of 0 and a legal kind, the result equals the operand and `cout_o` equals `cin_i`.
- R4: With a count of 0, `xout_o` keeps the value it had before that operation.
- R5: Kind 2'b00 (logical left) with count n in 1..31 gives operand << n, and the carry is operand bit 32−n.
- R6: Kind 2'b01 (logical right) and kind 2'b10 (arithmetic right, sign-filled) with count n in 1..31 give the shifted operand, and the carry is operand bit n−1.
- R7: A count of exactly 32 on a logical kind gives result 0. The carry is operand bit 0 for the left shift and operand bit 31 for the right shift.
- R8: A count above 32 on a logical kind gives result 0 and carry 0.
- R9: An arithmetic right shift by 32 or more gives 32 copies of operand bit 31, and the carry equals that bit.
- R10: For every nonzero count on a legal kind, `xout_o` equals `cout_o`.
- R11: Kind 2'b11 is reserved and acts like a zero count: the result is the operand, the carry is `cin_i`, and `xout_o` holds.
- R12: The outputs change only at a rising clock edge and reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| val_i | input | 32 | Operand to shift |
| cnt_i | input | 6 | Unsigned shift count |
| kind_i | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 reserved |
| cin_i | input | 1 | Carry flag before the operation |
| res_o | output | 32 | Shifted result (registered) |
| cout_o | output | 1 | Carry output (registered) |
| xout_o | output | 1 | Extend output (registered) |

## Verification
The assertions assume the inputs are stable and known at each rising edge. They relate each registered output only to input values captured after reset has been released. The stimulus changes inputs only on the falling edge and begins operations only after reset drops. The sweep covers every kind code, including the reserved one, and every count from 0 to 63, applied to operands with the sign bit set, clear, all ones, all zeros and mixed patterns. Because the incoming carry toggles with the count, the stimulus shows both pass-through of the carry and holding of the extend flag.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_RSV = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shf_rstage.sv
// Log-depth right shifter over a W+1 bit vector with a programmable fill bit.
module shf_rstage #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic [W:0]    din,
  input  logic [CW-1:0] amt,
  input  logic          fill,
  output logic [W:0]    dout
);
  logic [W:0] stg [0:CW];

  assign stg[0] = din;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int SH = 1 << k;
    if (SH >= W + 1) begin : g_full
      assign stg[k+1] = amt[k] ? {(W+1){fill}} : stg[k];
    end else begin : g_part
      assign stg[k+1] = amt[k] ? {{SH{fill}}, stg[k][W:SH]} : stg[k];
    end
  end

  assign dout = stg[CW];
endmodule

// File: rtl/shf_core.sv
// Combinational shift datapath: a left shift is a right shift of the
// bit-reversed operand. One guard bit below the operand catches the carry.
module shf_core
  import shf_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic [W-1:0]  val,
  input  logic [CW-1:0] cnt,
  input  shift_kind_e   kind,
  output logic [W-1:0]  res,
  output logic          carry
);
  logic [W-1:0] src;
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic [W:0]   sh_out;
  logic         is_left;
  logic         fill;

  assign is_left = (kind == SK_LSL);
  assign fill    = (kind == SK_ASR) & val[W-1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = val[W-1-i];
    assign rev_out[i] = sh_out[W-i];
  end

  assign src = is_left ? rev_in : val;

  shf_rstage #(.W(W), .CW(CW)) u_rs (
    .din  ({src, 1'b0}),
    .amt  (cnt),
    .fill (fill),
    .dout (sh_out)
  );

  assign res   = is_left ? rev_out : sh_out[W:1];
  assign carry = sh_out[0];
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  val_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [1:0]    kind_i,
  input  logic          cin_i,
  output logic [W-1:0]  res_o,
  output logic          cout_o,
  output logic          xout_o
);
  localparam logic [CW-1:0] CNT_W = CW'(W);

  shift_kind_e  kind;
  logic [W-1:0] core_res;
  logic         core_c;
  logic         pass;

  assign kind = shift_kind_e'(kind_i);
  assign pass = (cnt_i == '0) || (kind == SK_RSV);

  shf_core #(.W(W), .CW(CW)) u_core (
    .val   (val_i),
    .cnt   (cnt_i),
    .kind  (kind),
    .res   (core_res),
    .carry (core_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      cout_o <= 1'b0;
      xout_o <= 1'b0;
    end else if (pass) begin
      res_o  <= val_i;
      cout_o <= cin_i;
    end else begin
      res_o  <= core_res;
      cout_o <= core_c;
      xout_o <= core_c;
    end
  end

  // Set once an edge has passed with reset low, so $past sees live inputs.
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R3
  zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(cnt_i) == '0 |-> res_o == $past(val_i) && cout_o == $past(cin_i));

  // R4 R11
  ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && ($past(cnt_i) == '0 || $past(kind_i) == 2'b11) |-> xout_o == $past(xout_o));

  // R10
  ext_match_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(cnt_i) != '0 && $past(kind_i) != 2'b11 |-> xout_o == cout_o);

  // R8
  far_zero_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(cnt_i) > CNT_W && $past(kind_i[1]) == 1'b0 |-> res_o == '0 && !cout_o);

  // R9
  asr_fill_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(cnt_i) >= CNT_W && $past(kind_i) == 2'b10
    |-> res_o == {W{$past(val_i[W-1])}} && cout_o == $past(val_i[W-1]));
endmodule

// File: tb/sim_shf_unit.sv
`timescale 1ns/1ps
module sim_shf_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] val_i = '0;
  logic [5:0]  cnt_i = '0;
  logic [1:0]  kind_i = '0;
  logic        cin_i = 1'b0;
  logic [31:0] res_o;
  logic        cout_o;
  logic        xout_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  shf_unit u0 (
    .clk(clk), .rst(rst), .val_i(val_i), .cnt_i(cnt_i), .kind_i(kind_i),
    .cin_i(cin_i), .res_o(res_o), .cout_o(cout_o), .xout_o(xout_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (val=%h cnt=%0d kind=%0d)",
               tag, act, exp, val_i, cnt_i, kind_i);
    end
  endtask

  function automatic string res_tag(input int k, input int n);
    if (k == 3) return "R11";
    if (n == 0) return "R3";
    if (n < 32) return (k == 0) ? "R5" : "R6";
    if (k == 2) return "R9";
    if (n == 32) return "R7";
    if (n >= 48) return "R2";
    return "R8";
  endfunction

  localparam logic [31:0] PATS [0:8] = '{
    32'h8000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678, 32'hA5A5_5A5A,
    32'h7FFF_FFFE, 32'h0000_0001, 32'h8000_0000, 32'hDEAD_BEEF
  };

  logic [31:0] e_res = '0;
  logic        e_c   = 1'b0;
  logic        e_x   = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", res_o, 32'h0);
    chk("R1", {31'b0, cout_o}, 32'h0);
    chk("R1", {31'b0, xout_o}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < 9; p++) begin
      for (int k = 0; k < 4; k++) begin
        for (int n = 0; n < 64; n++) begin
          logic [63:0] wide;
          logic [31:0] r;
          logic        c;
          @(negedge clk);
          val_i  = PATS[p];
          cnt_i  = 6'(n);
          kind_i = 2'(k);
          cin_i  = n[0] ^ k[0] ^ p[0];
          #1;
          // R12 outputs must not move before the edge
          chk("R12", res_o, e_res);
          if (k == 0) begin
            wide = {32'b0, PATS[p]} << n;
            r = wide[31:0];
            c = wide[32];
          end else if (k == 1) begin
            wide = {PATS[p], 32'b0} >> n;
            r = wide[63:32];
            c = wide[31];
          end else begin
            wide = $signed({PATS[p], 32'b0}) >>> n;
            r = wide[63:32];
            c = wide[31];
          end
          if (n == 0 || k == 3) begin
            r = PATS[p];
            c = cin_i;
          end else begin
            e_x = c;
          end
          e_res = r;
          e_c   = c;
          @(posedge clk);
          #1;
          chk(res_tag(k, n), res_o, e_res);
          chk(res_tag(k, n), {31'b0, cout_o}, {31'b0, e_c});
          chk((n == 0 || k == 3) ? "R4" : "R10", {31'b0, xout_o}, {31'b0, e_x});
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule